// File: doc/BRIEF.md
# CAN Overload Condition Detector

This block watches the bit stream that a CAN protocol engine samples from the bus and decides when the engine has to start an overload frame. The engine supplies the sampled bit, a strobe that marks the sample point, a code for the field the bit belongs to, the index of the bit inside that field, and a flag that is high while the node is a receiver. The detector starts overload frames only in response to what it sees on the bus. Three dominant-bit positions count as overload conditions. A node that is not ready to receive cannot request one.

When one of the three positions carries a dominant bit at its sample strobe, the detector raises `ovl_start` for one clock in the cycle after the strobe. At the same time it reports a cause code. The engine uses that pulse to begin the overload flag at the next bit. The detector does not generate the frame bits, count errors or produce bit timing.

Top module: `can_ovl_detect`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `ovl_start` is 0 and `ovl_cause` is 0, whatever the other inputs do.
- R2: A dominant bit (`bit_val` = 0) sampled in the intermission field (`fld` = 1) at index 0 or 1 gives `ovl_start` = 1 and `ovl_cause` = 1 in the clock after the strobe.
- R3: A dominant bit at intermission index 2 starts no overload frame, because it marks the start of a new frame.
- R4: A dominant bit at index 6, the last bit of end-of-frame (`fld` = 2), sampled while `is_rx` = 1, gives `ovl_start` = 1 and `ovl_cause` = 2 in the clock after the strobe.
- R5: A dominant bit at end-of-frame index 6 sampled while `is_rx` = 0 starts no overload frame.
- R6: A dominant bit at index 7, the last bit of an error delimiter (`fld` = 3) or an overload delimiter (`fld` = 4), gives `ovl_start` = 1 and `ovl_cause` = 3 in the clock after the strobe.
- R7: No other bit starts an overload frame. This covers recessive bits (`bit_val` = 1), every other index, and field code 0 (any other field).
- R8: Nothing changes the outputs while `smp_stb` is low. Each strobe produces at most one pulse, and the pulse lasts one clock.
- R9: `ovl_cause` is 0 in every cycle in which `ovl_start` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | One-cycle strobe at the bit sample point |
| bit_val | input | 1 | Sampled bus bit, 0 = dominant |
| fld | input | 3 | Field code: 0 other, 1 intermission, 2 end-of-frame, 3 error delimiter, 4 overload delimiter |
| bit_idx | input | IDX_W | Zero-based index of the bit within its field |
| is_rx | input | 1 | High while the node is receiving |
| ovl_start | output | 1 | One-clock pulse that requests an overload frame |
| ovl_cause | output | 2 | 1 intermission, 2 end-of-frame, 3 delimiter, 0 when idle |

## Verification
On every cycle, the assertions check the mapping from each trigger position to a pulse and its cause code. They also check that no pulse follows a recessive bit, a cycle without a strobe, or an end-of-frame bit sampled while transmitting, and that the cause code is 0 between pulses. Other behaviour needs the bench's scenarios. These scenarios show that the third intermission bit, neighbouring indices and the catch-all field code stay silent. They also show that a strobe during reset has no effect, and that the pulse lasts a single clock.

// File: rtl/can_ovl_detect.sv
module can_ovl_detect #(
  parameter int IDX_W    = 3,
  parameter int IFS_TRIG = 2,
  parameter int EOF_LEN  = 7,
  parameter int DLM_LEN  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_stb,
  input  logic             bit_val,
  input  logic [2:0]       fld,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             is_rx,
  output logic             ovl_start,
  output logic [1:0]       ovl_cause
);
  localparam logic [2:0] F_IFS = 3'd1;
  localparam logic [2:0] F_EOF = 3'd2;
  localparam logic [2:0] F_ERD = 3'd3;
  localparam logic [2:0] F_OVD = 3'd4;
  localparam logic [IDX_W-1:0] IFS_LAST = IDX_W'(IFS_TRIG - 1);
  localparam logic [IDX_W-1:0] EOF_LAST = IDX_W'(EOF_LEN - 1);
  localparam logic [IDX_W-1:0] DLM_LAST = IDX_W'(DLM_LEN - 1);

  logic dom;
  logic hit_ifs, hit_eof, hit_dlm;
  logic [1:0] cause_nxt;

  assign dom     = smp_stb && !bit_val;
  assign hit_ifs = dom && fld == F_IFS && bit_idx <= IFS_LAST;
  assign hit_eof = dom && fld == F_EOF && bit_idx == EOF_LAST && is_rx;
  assign hit_dlm = dom && (fld == F_ERD || fld == F_OVD) && bit_idx == DLM_LAST;

  always_comb begin
    cause_nxt = 2'd0;
    if (hit_ifs)      cause_nxt = 2'd1;
    else if (hit_eof) cause_nxt = 2'd2;
    else if (hit_dlm) cause_nxt = 2'd3;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovl_start <= 1'b0;
      ovl_cause <= 2'd0;
    end else begin
      ovl_start <= cause_nxt != 2'd0;
      ovl_cause <= cause_nxt;
    end
  end
endmodule

// File: rtl/can_ovl_detect_chk.sv
module can_ovl_detect_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_stb,
  input logic             bit_val,
  input logic [2:0]       fld,
  input logic [IDX_W-1:0] bit_idx,
  input logic             is_rx,
  input logic             ovl_start,
  input logic [1:0]       ovl_cause
);
  a_r2_ifs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && !bit_val && fld == 3'd1 && bit_idx < IDX_W'(2)) |=> (ovl_start && ovl_cause == 2'd1));

  a_r4_eof_rx_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && !bit_val && fld == 3'd2 && bit_idx == IDX_W'(6) && is_rx) |=> (ovl_start && ovl_cause == 2'd2));

  a_r5_eof_tx_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && fld == 3'd2 && !is_rx) |=> !ovl_start);

  a_r6_dlm_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && !bit_val && (fld == 3'd3 || fld == 3'd4) && bit_idx == IDX_W'(7)) |=> (ovl_start && ovl_cause == 2'd3));

  a_r7_recessive_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_val) |=> !ovl_start);

  a_r8_no_strobe_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_stb) |=> !ovl_start);

  a_r9_idle_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovl_start) |-> (ovl_cause == 2'd0));
endmodule

bind can_ovl_detect can_ovl_detect_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .bit_val(bit_val),
  .fld(fld), .bit_idx(bit_idx), .is_rx(is_rx),
  .ovl_start(ovl_start), .ovl_cause(ovl_cause)
);

// File: tb/tb_can_ovl_detect.sv
module tb_can_ovl_detect;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  // {fld[3], idx[3], bit, rx, exp_pulse, exp_cause[2]}
  localparam logic [10:0] VEC [NV] = '{
    {3'd1, 3'd0, 1'b0, 1'b1, 1'b1, 2'd1},
    {3'd1, 3'd1, 1'b0, 1'b0, 1'b1, 2'd1},
    {3'd1, 3'd2, 1'b0, 1'b1, 1'b0, 2'd0},
    {3'd1, 3'd0, 1'b1, 1'b1, 1'b0, 2'd0},
    {3'd2, 3'd6, 1'b0, 1'b1, 1'b1, 2'd2},
    {3'd2, 3'd6, 1'b0, 1'b0, 1'b0, 2'd0},
    {3'd2, 3'd5, 1'b0, 1'b1, 1'b0, 2'd0},
    {3'd3, 3'd7, 1'b0, 1'b0, 1'b1, 2'd3},
    {3'd4, 3'd7, 1'b0, 1'b1, 1'b1, 2'd3},
    {3'd3, 3'd6, 1'b0, 1'b1, 1'b0, 2'd0},
    {3'd4, 3'd7, 1'b1, 1'b1, 1'b0, 2'd0},
    {3'd0, 3'd7, 1'b0, 1'b1, 1'b0, 2'd0},
    {3'd2, 3'd6, 1'b1, 1'b1, 1'b0, 2'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0, smp_stb = 1'b0, bit_val = 1'b1, is_rx = 1'b0;
  logic [2:0] fld = 3'd0;
  logic [2:0] bit_idx = 3'd0;
  logic ovl_start;
  logic [1:0] ovl_cause;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_ovl_detect dut (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .bit_val(bit_val),
    .fld(fld), .bit_idx(bit_idx), .is_rx(is_rx),
    .ovl_start(ovl_start), .ovl_cause(ovl_cause)
  );

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pulse/cause actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [10:0] v);
    if (v[2]) return (v[10:8] == 3'd1) ? "R2" : (v[10:8] == 3'd2) ? "R4" : "R6";
    if (v[10:8] == 3'd1 && v[7:5] == 3'd2 && !v[4]) return "R3";
    if (v[10:8] == 3'd2 && v[7:5] == 3'd6 && !v[4] && !v[3]) return "R5";
    return "R7";
  endfunction

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    // R1: trigger stimulus held during reset
    @(negedge clk);
    smp_stb = 1'b1; bit_val = 1'b0; fld = 3'd1; bit_idx = 3'd0;
    @(negedge clk);
    check("R1", {ovl_start, ovl_cause}, 3'b000);
    @(negedge clk);
    smp_stb = 1'b0; bit_val = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {ovl_start, ovl_cause}, 3'b000);

    for (int i = 0; i < NV; i++) begin
      fld = VEC[i][10:8]; bit_idx = VEC[i][7:5];
      bit_val = VEC[i][4]; is_rx = VEC[i][3];
      smp_stb = 1'b1;
      @(negedge clk);
      smp_stb = 1'b0; bit_val = 1'b1;
      check(tag_of(VEC[i]), {ovl_start, ovl_cause}, VEC[i][2:0]);
      @(negedge clk);
      check("R9", {ovl_start, ovl_cause}, 3'b000);
    end

    // R8: dominant at a trigger position without strobe
    fld = 3'd1; bit_idx = 3'd0; bit_val = 1'b0; is_rx = 1'b1;
    @(negedge clk);
    check("R8", {ovl_start, ovl_cause}, 3'b000);
    fld = 3'd4; bit_idx = 3'd7;
    @(negedge clk);
    check("R8", {ovl_start, ovl_cause}, 3'b000);

    // R8: single strobe gives a single-clock pulse while inputs stay dominant
    smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    check("R6", {ovl_start, ovl_cause}, 3'b111);
    @(negedge clk);
    check("R8", {ovl_start, ovl_cause}, 3'b000);
    bit_val = 1'b1;

    // R2: back-to-back intermission dominant bits each give a pulse
    fld = 3'd1; bit_idx = 3'd0; bit_val = 1'b0; smp_stb = 1'b1;
    @(negedge clk);
    check("R2", {ovl_start, ovl_cause}, 3'b101);
    bit_idx = 3'd1;
    @(negedge clk);
    smp_stb = 1'b0; bit_val = 1'b1;
    check("R2", {ovl_start, ovl_cause}, 3'b101);
    @(negedge clk);
    check("R9", {ovl_start, ovl_cause}, 3'b000);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule